// File: doc/BRIEF.md
# Configurable Pad I/O Cell

This block models one user-configurable I/O cell of a RAM-programmed gate array. It sits between a package pad and the core logic. On the input side it gives the core two results together: the resolved pad level passed straight through, and a stored copy of that level. The stored copy is held either by an edge-triggered flip-flop or by a level-sensitive latch. On the output side it drives a tri-state pad buffer. The buffer data comes either straight from the core or from an output flip-flop, and the data and the enable can each be inverted.

A static configuration word sets every option. The word is taken in while the global reset is high and held unchanged after release. Two clock lines are shared along a die edge. Each line has one polarity bit, and every storage element clocked from that line sees the same polarity. The pad is modelled as separate signals: the cell's drive value, the cell's drive enable, an external level and an external drive-present flag. An optional pull-up takes effect only while nothing drives the pad. Slew-rate and input-threshold options are stored as bits and have no logic effect.

Top module: `iocell_top`

## Requirements
- R1: `core_in_direct` equals the resolved pad level at all times, in the same cycle. While the cell drives the pad, this is the value the cell itself drives.
- R2: The pad level is resolved as follows. If `pad_oe` is 1, the level is `pad_out`. Otherwise, if `pad_ext_drive` is 1, the level is `pad_in`. Otherwise, if the pull-up bit (cfg bit 6) is 1, the level is 1. In these three cases `core_in_known` is 1. If none applies, `core_in_known` is 0 and the level reads as 0.
- R3: While `pad_oe` is 1, the pull-up bit has no effect on `core_in_direct` or `core_in_known`.
- R4: When cfg bit 0 is 0, the pad data follows `core_out` combinationally. When it is 1, the pad data comes from a flip-flop that captures `core_out` on the active edge of the output clock line.
- R5: cfg bit 1 inverts the pad data and cfg bit 2 inverts the drive enable. The two are independent: `pad_oe` is `core_oe` XOR bit 2.
- R6: When cfg bit 3 is 0, `core_in_stored` takes the resolved pad level present just before each active edge of the input clock line, and holds it between edges.
- R7: When cfg bit 3 is 1, `core_in_stored` follows the pad level while the selected line is at its opaque-free level. That level is low when the line's polarity bit is 0 and high when it is 1. At any other line level, `core_in_stored` holds its value.
- R8: The polarity of line 0 is cfg bit 7 and that of line 1 is cfg bit 8. A value of 0 makes the rising edge active, and 1 makes the falling edge active. Both storage elements obey the bit of the line they use.
- R9: cfg bit 4 picks the clock line of the input element and cfg bit 5 picks that of the output flip-flop. The two choices are independent.
- R10: A high `gsr` clears both storage elements asynchronously. Reset takes priority over any clock edge or latch enable.
- R11: cfg bits 9 and 10 (slew and threshold options) have no effect on any output.
- R12: The configuration word is taken in while `gsr` is high. Changes on `cfg_i` after reset release have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_i | input | 11 | Configuration word, bit fields as in R2 to R12 |
| clk_line | input | 2 | The two edge clock lines |
| gsr | input | 1 | Global asynchronous reset, active high |
| core_out | input | 1 | Output data from the core |
| core_oe | input | 1 | Drive enable from the core, before inversion |
| core_in_direct | output | 1 | Resolved pad level, passed straight through |
| core_in_stored | output | 1 | Stored pad level from flip-flop or latch |
| core_in_known | output | 1 | High when the pad level is defined |
| pad_out | output | 1 | Value the cell drives onto the pad |
| pad_oe | output | 1 | Cell drive enable toward the pad |
| pad_in | input | 1 | Level driven by an external source |
| pad_ext_drive | input | 1 | High while an external source drives the pad |

## Verification
The bench builds the block with its default of two clock lines, which gives an 11-bit configuration word. Random configuration words, each loaded during a reset, bring within reach every combination of source select, inversion, latch or flop mode, line choice and line polarity. This includes the cases where both elements share a line and the cases where the output flip-flop changes the pad level in the same step that the input element samples it. Directed cases cover a floating pad with and without the pull-up, the pull-up masked by an active driver, and clock activity during reset.

// File: rtl/iocell_pkg.sv
`timescale 1ns/1ps
package iocell_pkg;

  localparam int NLINES = 2;
  localparam int LSEL_W = (NLINES > 1) ? $clog2(NLINES) : 1;

  // Field order fixes the bit positions: out_src is bit 0, opt_thresh is the MSB.
  typedef struct packed {
    logic              opt_thresh;   // stored only, no logic effect
    logic              opt_slew;     // stored only, no logic effect
    logic [NLINES-1:0] line_pol;     // per-line polarity, 1 = falling edge active
    logic              pull_en;
    logic [LSEL_W-1:0] out_line;
    logic [LSEL_W-1:0] in_line;
    logic              in_latch;
    logic              oe_inv;
    logic              out_inv;
    logic              out_src;      // 1 = registered output
  } iocell_cfg_t;

  localparam int CFG_W = $bits(iocell_cfg_t);

  // Effective clock seen by storage elements: rising edge of this is active.
  function automatic logic line_active_high(input logic lvl, input logic pol);
    return lvl ^ pol;
  endfunction

  // Data driven toward the pad.
  function automatic logic drive_value(input logic use_reg, input logic reg_q,
                                       input logic direct, input logic inv);
    return (use_reg ? reg_q : direct) ^ inv;
  endfunction

  // Resolved pad level: {known, value}.
  function automatic logic [1:0] resolve_pad(input logic own_oe, input logic own_val,
                                             input logic ext_en, input logic ext_val,
                                             input logic pull);
    logic [1:0] r;
    if (own_oe)      r = {1'b1, own_val};
    else if (ext_en) r = {1'b1, ext_val};
    else if (pull)   r = 2'b11;
    else             r = 2'b00;
    return r;
  endfunction

endpackage

// File: rtl/iocell_clk_sel.sv
`timescale 1ns/1ps
module iocell_clk_sel
  import iocell_pkg::*;
#(
  parameter int NL = NLINES,
  parameter int SW = LSEL_W
) (
  input  logic [NL-1:0] lines,
  input  logic [NL-1:0] pol,
  input  logic [SW-1:0] sel,
  output logic          eff_clk
);

  logic [NL-1:0] eff_all;

  for (genvar g = 0; g < NL; g++) begin : g_line
    assign eff_all[g] = line_active_high(lines[g], pol[g]);
  end

  assign eff_clk = eff_all[sel];

endmodule

// File: rtl/iocell_in_store.sv
`timescale 1ns/1ps
module iocell_in_store (
  input  logic gsr,
  input  logic eff_clk,     // rising = flop edge; low = latch transparent
  input  logic latch_mode,
  input  logic d,
  output logic q
);

  logic       ff_q;
  logic       lat_q;
  logic [1:0] armed;

  always_ff @(posedge eff_clk or posedge gsr) begin
    if (gsr) ff_q <= 1'b0;
    else     ff_q <= d;
  end

  always_latch begin
    if (gsr)          lat_q <= 1'b0;
    else if (!eff_clk) lat_q <= d;
  end

  always_ff @(posedge eff_clk or posedge gsr) begin
    if (gsr)                 armed <= 2'd0;
    else if (armed != 2'd2)  armed <= armed + 2'd1;
  end

  assign q = latch_mode ? lat_q : ff_q;

  AST_IN_FLOP_CAPTURE: assert property (@(posedge eff_clk) disable iff (gsr)
    (armed == 2'd2) |-> (ff_q == $past(d)));   // R6

  always_comb begin
    if (!gsr && !eff_clk) begin
      AST_LATCH_TRANSPARENT: assert (lat_q == d);   // R7
    end
  end

endmodule

// File: rtl/iocell_out_path.sv
`timescale 1ns/1ps
module iocell_out_path
  import iocell_pkg::*;
(
  input  logic gsr,
  input  logic eff_clk,
  input  logic use_reg,
  input  logic out_inv,
  input  logic oe_inv,
  input  logic core_out,
  input  logic core_oe,
  output logic pad_out,
  output logic pad_oe
);

  logic       oq;
  logic [1:0] armed;

  always_ff @(posedge eff_clk or posedge gsr) begin
    if (gsr) oq <= 1'b0;
    else     oq <= core_out;
  end

  always_ff @(posedge eff_clk or posedge gsr) begin
    if (gsr)                armed <= 2'd0;
    else if (armed != 2'd2) armed <= armed + 2'd1;
  end

  assign pad_out = drive_value(use_reg, oq, core_out, out_inv);
  assign pad_oe  = core_oe ^ oe_inv;

  AST_OUT_FLOP_CAPTURE: assert property (@(posedge eff_clk) disable iff (gsr)
    (armed == 2'd2) |-> (oq == $past(core_out)));   // R4

endmodule

// File: rtl/iocell_pad_rx.sv
`timescale 1ns/1ps
module iocell_pad_rx
  import iocell_pkg::*;
(
  input  logic pad_oe,
  input  logic pad_out,
  input  logic ext_en,
  input  logic ext_val,
  input  logic pull_en,
  output logic lvl,
  output logic known
);

  logic [1:0] res;

  assign res   = resolve_pad(pad_oe, pad_out, ext_en, ext_val, pull_en);
  assign lvl   = res[0];
  assign known = res[1];

  always_comb begin
    if (pad_oe) begin
      AST_DRIVE_READBACK: assert (known && (lvl == pad_out));   // R3
    end
    if (!pad_oe && !ext_en && pull_en) begin
      AST_PULLUP_HIGH: assert (known && lvl);   // R2
    end
  end

endmodule

// File: rtl/iocell_top.sv
`timescale 1ns/1ps
module iocell_top
  import iocell_pkg::*;
(
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [NLINES-1:0] clk_line,
  input  logic              gsr,
  input  logic              core_out,
  input  logic              core_oe,
  output logic              core_in_direct,
  output logic              core_in_stored,
  output logic              core_in_known,
  output logic              pad_out,
  output logic              pad_oe,
  input  logic              pad_in,
  input  logic              pad_ext_drive
);

  iocell_cfg_t cfg_q;
  logic        in_eff_clk;
  logic        out_eff_clk;
  logic        pad_lvl;
  logic [1:0]  cfg_armed;

  // Configuration storage: open while reset is high, frozen afterwards.
  always_latch begin
    if (gsr) cfg_q <= iocell_cfg_t'(cfg_i);
  end

  iocell_clk_sel u_in_clk (
    .lines   (clk_line),
    .pol     (cfg_q.line_pol),
    .sel     (cfg_q.in_line),
    .eff_clk (in_eff_clk)
  );

  iocell_clk_sel u_out_clk (
    .lines   (clk_line),
    .pol     (cfg_q.line_pol),
    .sel     (cfg_q.out_line),
    .eff_clk (out_eff_clk)
  );

  iocell_out_path u_out (
    .gsr      (gsr),
    .eff_clk  (out_eff_clk),
    .use_reg  (cfg_q.out_src),
    .out_inv  (cfg_q.out_inv),
    .oe_inv   (cfg_q.oe_inv),
    .core_out (core_out),
    .core_oe  (core_oe),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  iocell_pad_rx u_rx (
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .ext_en  (pad_ext_drive),
    .ext_val (pad_in),
    .pull_en (cfg_q.pull_en),
    .lvl     (pad_lvl),
    .known   (core_in_known)
  );

  iocell_in_store u_in (
    .gsr        (gsr),
    .eff_clk    (in_eff_clk),
    .latch_mode (cfg_q.in_latch),
    .d          (pad_lvl),
    .q          (core_in_stored)
  );

  assign core_in_direct = pad_lvl;

  always_ff @(posedge clk_line[0] or posedge gsr) begin
    if (gsr)                    cfg_armed <= 2'd0;
    else if (cfg_armed != 2'd2) cfg_armed <= cfg_armed + 2'd1;
  end

  AST_CFG_FROZEN: assert property (@(posedge clk_line[0]) disable iff (gsr)
    (cfg_armed == 2'd2) |-> $stable(cfg_q));   // R12

  always_comb begin
    if (pad_oe) begin
      AST_DIRECT_SEES_DRIVE: assert (core_in_direct == pad_out);   // R1
    end
  end

endmodule

// File: tb/iocell_top_tb.sv
`timescale 1ns/1ps
module iocell_top_tb;
  import iocell_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [CFG_W-1:0]  cfg_i;
  logic [NLINES-1:0] clk_line;
  logic gsr, core_out, core_oe, pad_in, pad_ext_drive;
  logic core_in_direct, core_in_stored, core_in_known, pad_out, pad_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  iocell_top u_dut (
    .cfg_i(cfg_i), .clk_line(clk_line), .gsr(gsr),
    .core_out(core_out), .core_oe(core_oe),
    .core_in_direct(core_in_direct), .core_in_stored(core_in_stored),
    .core_in_known(core_in_known), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_in(pad_in), .pad_ext_drive(pad_ext_drive)
  );

  // Bench model state
  iocell_cfg_t mc;
  logic m_ff, m_lat, m_oq;

  // Edge of the selected line is active when the line goes toward (pol ? 0 : 1).
  function automatic logic tb_active(input logic [NLINES-1:0] ln, input iocell_cfg_t c,
                                     input logic [LSEL_W-1:0] s);
    if (c.line_pol[s]) return ~ln[s];
    return ln[s];
  endfunction

  function automatic logic tb_drive(input iocell_cfg_t c, input logic oq, input logic od);
    logic v;
    v = c.out_src ? oq : od;
    if (c.out_inv) v = ~v;
    return v;
  endfunction

  function automatic logic tb_oe(input iocell_cfg_t c, input logic t);
    return c.oe_inv ? ~t : t;
  endfunction

  // {known, value}
  function automatic logic [1:0] tb_level(input iocell_cfg_t c, input logic oq,
                                          input logic od, input logic t,
                                          input logic ext, input logic pin);
    if (tb_oe(c, t)) return {1'b1, tb_drive(c, oq, od)};
    if (ext)         return {1'b1, pin};
    if (c.pull_en)   return 2'b11;
    return 2'b00;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    logic [1:0] lv;
    lv = tb_level(mc, m_oq, core_out, core_oe, pad_ext_drive, pad_in);
    chk("R1/R3", core_in_direct, lv[0]);
    chk("R2", core_in_known, lv[1]);
    chk("R4/R5/R12", pad_out, tb_drive(mc, m_oq, core_out));
    chk("R5/R11", pad_oe, tb_oe(mc, core_oe));
    if (mc.in_latch) chk("R7/R8/R9", core_in_stored, m_lat);
    else             chk("R6/R8/R9", core_in_stored, m_ff);
  endtask

  // Load a configuration under reset; clock lines toggle during reset (R10).
  task automatic do_reset(input logic [CFG_W-1:0] c);
    iocell_cfg_t cc;
    cc = iocell_cfg_t'(c);
    @(negedge clk);
    gsr = 1'b1;
    cfg_i = c;
    pad_ext_drive = 1'b1;
    pad_in = 1'b1;
    core_out = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #0.5 clk_line = NLINES'($urandom);
    end
    #0.5;
    m_ff = 1'b0; m_lat = 1'b0; m_oq = 1'b0;
    mc = cc;
    // R10: cleared despite edges and open latch enable while reset is high
    chk("R10", core_in_stored, 1'b0);
    chk("R10", pad_out, tb_drive(cc, 1'b0, core_out));
    gsr = 1'b0;
    #0.5;
    cfg_i = ~c;   // R12: later changes must be ignored
  endtask

  // One step: data change, then line change, then check.
  task automatic step(input logic rnd, input logic od, input logic t,
                      input logic pin, input logic ext, input logic [NLINES-1:0] ln);
    logic [1:0] lv_a, lv_b;
    logic ei_old, ei_new, eo_old, eo_new;
    logic [NLINES-1:0] nl;
    @(negedge clk);
    if (rnd) begin
      core_out = 1'($urandom); core_oe = 1'($urandom);
      pad_in = 1'($urandom); pad_ext_drive = 1'($urandom);
      nl = NLINES'($urandom);
      cfg_i = CFG_W'($urandom);
    end else begin
      core_out = od; core_oe = t; pad_in = pin; pad_ext_drive = ext; nl = ln;
    end
    lv_a = tb_level(mc, m_oq, core_out, core_oe, pad_ext_drive, pad_in);
    ei_old = tb_active(clk_line, mc, mc.in_line);
    if (!ei_old) m_lat = lv_a[0];
    #1;
    ei_new = tb_active(nl, mc, mc.in_line);
    eo_old = tb_active(clk_line, mc, mc.out_line);
    eo_new = tb_active(nl, mc, mc.out_line);
    if (!ei_old && ei_new) m_ff = lv_a[0];
    if (!eo_old && eo_new) m_oq = core_out;
    clk_line = nl;
    lv_b = tb_level(mc, m_oq, core_out, core_oe, pad_ext_drive, pad_in);
    if (!ei_new) m_lat = lv_b[0];
    #1;
    check_outputs();
  endtask

  initial begin
    iocell_cfg_t c;
    gsr = 1'b1; cfg_i = '0; clk_line = '0;
    core_out = 0; core_oe = 0; pad_in = 0; pad_ext_drive = 0;
    void'($urandom(32'd1234));

    // Floating pad without pull-up: level undefined (R2)
    c = '0;
    do_reset(CFG_W'(c));
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    chk("R2", core_in_known, 1'b0);

    // Floating pad with pull-up reads 1 (R2)
    c.pull_en = 1'b1;
    do_reset(CFG_W'(c));
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk("R2", core_in_direct, 1'b1);

    // Pull-up masked while the cell drives 0 (R3), same-cycle readback (R1)
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0);
    chk("R3", core_in_direct, 1'b0);
    chk("R1", core_in_known, 1'b1);

    // Latch mode on line 1 with falling polarity, registered inverted output (R7, R8, R9)
    c = '0;
    c.in_latch = 1'b1; c.in_line = 1'b1; c.line_pol = 2'b10;
    c.out_src = 1'b1; c.out_inv = 1'b1;
    do_reset(CFG_W'(c));
    for (int k = 0; k < 40; k++) step(1'b1, 0, 0, 0, 0, '0);

    // Random configurations, slew/threshold bits included (R11)
    for (int n = 0; n < 24; n++) begin
      do_reset(CFG_W'($urandom));
      for (int k = 0; k < 300; k++) step(1'b1, 0, 0, 0, 0, '0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule